// File: doc/BRIEF.md
# Cascaded Core Clock Divider Chain

The block takes up to four PLL source ticks, each a one-cycle enable pulse in the system clock domain. It picks one of them and runs it through four dividers connected in series. Each divider counts only the ticks of the stage before it, so its output rate is the selected source rate divided by the product of its own ratio and every ratio above it. The four outputs give the fast, bus, peripheral and slow derived clock enables of a core clock tree. Downstream logic uses them as clock enables.

All of this is set by one 32-bit control word. Bits [2:0] choose the source. Four 6-bit fields hold the divide ratios minus one. A write does not disturb the running chain: the new word waits as pending and takes effect in the cycle in which every stage rolls over together. The read port always shows the word that is in force.

Top module: `clkchain_top`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0 (source 0, all ratios 1) and `tick_out` is 0.
- R2: Source codes 0 to 3 in control bits [2:0] select `src_tick[code]`. Ticks on the sources that are not selected have no effect on any output.
- R3: Source codes 4 to 7 select no clock, and every bit of `tick_out` stays 0 while such a word is in force.
- R4: Stage k takes its ratio from control bits [3+6k +: 6], and the ratio equals the field value plus one (1 to 64). Stage 0 uses bits [8:3], stage 1 bits [14:9], stage 2 bits [20:15] and stage 3 bits [26:21].
- R5: Counting from the cycle in which a word takes effect, the number of pulses on `tick_out[k]` after N selected source ticks is floor(N / (ratio0 × … × ratiok)).
- R6: Each output pulse lasts one clock and appears exactly one clock after the source tick that completes it. With all ratios at 1, a single source tick gives one pulse on all four outputs in the next cycle.
- R7: A written word is held pending, and `rd_data` keeps the old word until the pending one is applied. It is applied at the clock edge after which all four stage counters are at zero, and it then takes effect with every stage starting a fresh period. A later write before that point replaces the pending word.
- R8: `tick_out[k]` for k ≥ 1 pulses only in a cycle in which `tick_out[k-1]` also pulses.
- R9: Control bits [31:27] are not stored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word currently in force |
| src_tick | input | 4 | One-cycle tick inputs from the four PLL sources |
| tick_out | output | 4 | Registered one-cycle output ticks of stages 0 to 3 |

## Verification
A stage counter that drifts, or a ratio field taken from the wrong bits, changes the pulse count on that output and on every output below it. This shows within one full period of the slowest stage, so the bench compares per-output counts over windows that are whole multiples of the product of the ratios. A pending word applied at the wrong moment shows at once on `rd_data`, because the bench reads it back both one tick before and one tick after the common rollover. A wrong source decode shows as pulses from a noisy source that is not selected, or as pulses while an idle code is in force.

// File: rtl/clkchain_pkg.sv
package clkchain_pkg;
  // Default layout of the control word
  localparam int DEF_CTRL_W  = 32;
  localparam int DEF_SEL_W   = 3;
  localparam int DEF_RATIO_W = 6;
  localparam int DEF_NUM_SRC = 4;
  localparam int DEF_STAGES  = 4;

  // Bit position of the ratio field of stage k
  function automatic int field_lsb(input int sel_w, input int ratio_w, input int k);
    return sel_w + k * ratio_w;
  endfunction
endpackage

// File: rtl/clkchain_ctrl.sv
module clkchain_ctrl #(
  parameter int CTRL_W = 32,
  parameter int USED_W = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              roll_ok,
  output logic [CTRL_W-1:0] act_word
);
  logic [CTRL_W-1:0] pend_word;
  logic              pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_word  <= '0;
      pend_word <= '0;
      pend_v    <= 1'b0;
    end else begin
      if (pend_v && roll_ok) begin
        act_word <= pend_word;
      end
      if (wr_en) begin
        pend_word <= CTRL_W'(wr_data[USED_W-1:0]);
        pend_v    <= 1'b1;
      end else if (roll_ok) begin
        pend_v    <= 1'b0;
      end
    end
  end

  // R7
  held_without_pending_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_v |=> $stable(act_word));
endmodule

// File: rtl/clkchain_srcsel.sv
module clkchain_srcsel #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  output logic               sel_tick
);
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign hit[i] = src_tick[i] && (sel == SEL_W'(i));
  end

  assign sel_tick = |hit;
endmodule

// File: rtl/clkchain_stage.sv
module clkchain_stage #(
  parameter int RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_tick,
  input  logic [RATIO_W-1:0] ratio_m1,
  output logic               fire,
  output logic               zero_nxt,
  output logic               cnt_zero,
  output logic               tick_q
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] cnt_nxt;
  logic               at_end;

  assign at_end   = (cnt == ratio_m1);
  assign fire     = in_tick && at_end;
  assign zero_nxt = (cnt_nxt == '0);
  assign cnt_zero = (cnt == '0);

  always_comb begin
    cnt_nxt = cnt;
    if (in_tick) begin
      cnt_nxt = at_end ? '0 : cnt + RATIO_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      tick_q <= fire;
    end
  end

  // R5
  count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= ratio_m1);
endmodule

// File: rtl/clkchain_top.sv
module clkchain_top
  import clkchain_pkg::*;
#(
  parameter int CTRL_W  = DEF_CTRL_W,
  parameter int SEL_W   = DEF_SEL_W,
  parameter int RATIO_W = DEF_RATIO_W,
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int STAGES  = DEF_STAGES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CTRL_W-1:0]  wr_data,
  output logic [CTRL_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic [STAGES-1:0]  tick_out
);
  localparam int USED_W = SEL_W + STAGES * RATIO_W;

  logic [CTRL_W-1:0] act_word;
  logic [SEL_W-1:0]  act_sel;
  logic              sel_tick;
  logic              roll_ok;
  logic [STAGES-1:0] fire;
  logic [STAGES-1:0] zero_nxt;
  logic [STAGES-1:0] cnt_zero;
  logic [STAGES-1:0] stage_in;

  assign act_sel = act_word[SEL_W-1:0];
  assign roll_ok = &zero_nxt;
  assign rd_data = act_word;

  clkchain_ctrl #(.CTRL_W(CTRL_W), .USED_W(USED_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .roll_ok(roll_ok), .act_word(act_word)
  );

  clkchain_srcsel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .src_tick(src_tick), .sel(act_sel), .sel_tick(sel_tick)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int LSB = field_lsb(SEL_W, RATIO_W, k);
    if (k == 0) begin : g_head
      assign stage_in[k] = sel_tick;
    end else begin : g_link
      assign stage_in[k] = fire[k-1];
    end
    clkchain_stage #(.RATIO_W(RATIO_W)) u_stage (
      .clk(clk), .rst(rst), .in_tick(stage_in[k]),
      .ratio_m1(act_word[LSB +: RATIO_W]),
      .fire(fire[k]), .zero_nxt(zero_nxt[k]), .cnt_zero(cnt_zero[k]),
      .tick_q(tick_out[k])
    );
  end

  // R8
  for (genvar k = 1; k < STAGES; k++) begin : g_order
    cascade_order_chk: assert property (@(posedge clk) disable iff (rst)
      tick_out[k] |-> tick_out[k-1]);
  end

  // R6
  pulse_source_chk: assert property (@(posedge clk) disable iff (rst)
    (|tick_out) |-> $past(sel_tick));

  // R3
  idle_source_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(act_sel) >= SEL_W'(NUM_SRC)) |-> (tick_out == '0));

  // R7
  apply_at_rollover_chk: assert property (@(posedge clk) disable iff (rst)
    (act_word != $past(act_word)) |-> (&cnt_zero));
endmodule

// File: tb/tb_clkchain_top.sv
module tb_clkchain_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  src_tick = '0;
  logic [3:0]  tick_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { int c[4]; string tag; } exp_t;
  exp_t exp_q[$];
  bit   win_open = 0;
  bit   was_open = 0;
  int   seen[4];

  always #4 clk = ~clk;

  clkchain_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_tick(src_tick), .tick_out(tick_out)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: counts pulses per output in a window, pops and compares
  always @(negedge clk) begin
    if (win_open) begin
      for (int k = 0; k < 4; k++) if (tick_out[k]) seen[k]++;
      was_open = 1;
    end else if (was_open) begin
      exp_t e;
      e = exp_q.pop_front();
      for (int k = 0; k < 4; k++) begin
        chk(seen[k], e.c[k], $sformatf("%s out%0d", e.tag, k));
        seen[k] = 0;
      end
      was_open = 0;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = w;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_apply(input logic [31:0] w, input string tag);
    bit ok = 0;
    for (int i = 0; i < 100 && !ok; i++) begin
      @(negedge clk);
      if (rd_data == (w & 32'h07FF_FFFF)) ok = 1;
    end
    chk(int'(ok), 1, tag);
  endtask

  function automatic int ratio(input logic [31:0] w, input int k);
    return int'((w >> (3 + 6 * k)) & 32'h3F) + 1;
  endfunction

  task automatic drive_ticks(input logic [3:0] tv, input logic [3:0] gv,
                             input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; src_tick = tv;
      if (gap) begin
        @(posedge clk); #1; src_tick = gv;
      end
    end
    @(posedge clk); #1; src_tick = '0;
  endtask

  // Driver: applies a word, pushes the expected counts, drives the window
  task automatic run_window(input logic [31:0] w, input int n, input bit gap,
                            input logic [3:0] tv, input logic [3:0] gv,
                            input string tag);
    exp_t e;
    int   prod = 1;
    write_word(w);
    wait_apply(w, {tag, " applied"});
    for (int k = 0; k < 4; k++) begin
      prod = prod * ratio(w, k);
      e.c[k] = (w[2:0] < 3'd4) ? n / prod : 0;
    end
    e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk); #1; win_open = 1;
    drive_ticks(tv, gv, n, gap);
    cyc(2);
    win_open = 0;
    cyc(2);
  endtask

  function automatic logic [31:0] mk(input int s, input int r0, input int r1,
                                     input int r2, input int r3);
    return 32'(s) | (32'(r0 - 1) << 3) | (32'(r1 - 1) << 9) |
           (32'(r2 - 1) << 15) | (32'(r3 - 1) << 21);
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] wa, wb;
    for (int k = 0; k < 4; k++) seen[k] = 0;
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(int'(rd_data), 0, "R1 rd_data");
    chk(int'(tick_out), 0, "R1 tick_out");

    // R6 one-cycle latency and width with all ratios 1
    @(posedge clk); #1; src_tick = 4'b0001;
    @(posedge clk); #1; src_tick = 4'b0000;
    @(negedge clk);
    chk(int'(tick_out), 15, "R6 pulse next cycle");
    @(negedge clk);
    chk(int'(tick_out), 0, "R6 pulse width");

    // R5 R2 continuous ticks, source 0, ratios 1
    run_window(mk(0, 1, 1, 1, 1), 10, 0, 4'b0001, 4'b0000, "R5 unity");
    // R2 R4 R5 source 2 with noise on other sources
    run_window(mk(2, 3, 2, 4, 1), 48, 1, 4'b0101, 4'b1010, "R2 src2 noisy");
    // R4 maximum ratio 64 on stage 0
    run_window(mk(1, 64, 1, 1, 1), 128, 0, 4'b0010, 4'b0000, "R4 ratio64");
    // R4 R5 source 3, lower stages divide by 2
    run_window(mk(3, 1, 2, 2, 2), 16, 1, 4'b1001, 4'b0001, "R4 src3");

    // R9 upper bits not stored
    write_word(32'hFFFF_FFFF);
    wait_apply(32'hFFFF_FFFF, "R9 apply");
    chk(int'(rd_data[31:27]), 0, "R9 upper bits");
    // R3 idle source code 5
    run_window(mk(5, 1, 1, 1, 1), 8, 0, 4'b1111, 4'b0000, "R3 idle");

    // R7 pending until common rollover (product 12)
    wa = mk(0, 2, 3, 1, 2);
    wb = mk(1, 1, 1, 1, 1);
    write_word(wa);
    wait_apply(wa, "R7 first word");
    drive_ticks(4'b0001, 4'b0000, 5, 0);
    write_word(32'h0000_0003);
    write_word(wb);
    drive_ticks(4'b0001, 4'b0000, 6, 0);
    @(negedge clk);
    chk(int'(rd_data), int'(wa), "R7 held before rollover");
    drive_ticks(4'b0001, 4'b0000, 1, 0);
    @(negedge clk);
    chk(int'(rd_data), int'(wb), "R7 applied at rollover");
    // R8 implied: cascade counts after switch
    run_window(mk(0, 2, 2, 2, 2), 32, 0, 4'b0001, 4'b0000, "R8 halving");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule